// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Serial Bus

This block is an I2C target that gives a host read and write access to a small bank of byte-wide configuration registers. The protocol is indexed and carries a byte count. On a write, the host sends the write address and then a starting index. After the index comes a byte count, followed by that many data bytes. The data bytes land in consecutive registers. On a read, the host first sets the index with a short write and then issues a repeated START with the read address. The target then returns a count byte, followed by the register contents from the chosen index onward.

The block works entirely in the system clock domain. SCL and SDA are each resynchronised through a two-flop chain, and START and STOP are detected from the synchronised lines. The target pulls SDA low through an output enable and otherwise leaves the line to the pull-up. The whole register bank is presented as one flat vector, so neighbouring logic can read any field directly.

Top module: `i2c_idx_regslave`

## Requirements
- R1: The target answers the 8-bit address bytes 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth clock. Both bytes carry the 7-bit address 0x69 in bits 7..1 and the read flag in bit 0.
- R2: In a write, the target acknowledges the index byte, the count byte and each data byte. Data byte k is stored in register N+k, where N is the index byte's low 4 bits.
- R3: Register numbering wraps modulo 16, so a write or read that runs past register 15 continues at register 0.
- R4: In a write, data bytes beyond the stated count are not acknowledged and are not stored.
- R5: After a repeated START with 0xD3, the target sends registers N, N+1, ... in turn for as long as the host acknowledges. Bits go out most significant first.
- R6: When the host answers a byte with NACK (SDA high in the ninth clock), the target stops driving SDA until the next START.
- R7: The first byte of every read is the count from the most recent write transaction. Its value after reset is 16.
- R8: After an address byte other than 0xD2 or 0xD3, the target does not acknowledge, leaves SDA released and ignores all bytes until the next START.
- R9: A START or STOP in the middle of a byte abandons the transfer. A data byte is stored only once its ACK clock has finished.
- R10: The target changes SDA from released to driven only while SCL is low.
- R11: After reset, every register is 0 and SDA is released.
- R12: Register i appears on regs_o bits 8i+7 down to 8i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low; low to release it |
| regs_o | output | 128 | Flat register bank, register i at bits 8i+7..8i |

## Verification
Several properties are checked on every cycle by the assertions: the target never starts driving SDA while SCL is high, and the bit counter never passes eight. A START always restarts address reception, and a STOP always releases the line. The ignore state never drives SDA, and the register bank changes only on a write strobe. Only the bench's bus scenarios can show the protocol-level outcomes. These are the count byte and register stream of a read, wrap-around past register 15, NACK of surplus data bytes, silence after a foreign address, and the loss of half-received bytes on an aborted transfer.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } fsm_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // index 1 = scl, index 0 = sda
    logic [1:0] chain_q [SYNC_STAGES];
    logic [1:0] prev_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 2'b11;
                else        chain_q[g] <= {scl_i, sda_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 2'b11;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    logic [1:0] now_w;
    assign now_w      = chain_q[SYNC_STAGES-1];
    assign scl_o      = now_w[1];
    assign sda_o      = now_w[0];
    assign scl_rise_o = !prev_q[1] &&  now_w[1];
    assign scl_fall_o =  prev_q[1] && !now_w[1];
    assign start_o    =  prev_q[1] &&  now_w[1] &&  prev_q[0] && !now_w[0];
    assign stop_o     =  prev_q[1] &&  now_w[1] && !prev_q[0] &&  now_w[0];

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
    parameter int NREGS = 16,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [7:0]            rd_data,
    output logic [NREGS*8-1:0]    regs_o
);
    logic [NREGS-1:0][7:0] regs_d, regs_q;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        always_comb begin
            regs_d[r] = regs_q[r];
            if (wr_en && (wr_idx == IDXW'(r))) regs_d[r] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_data = regs_q[rd_idx];
    assign regs_o  = regs_q;

    // R4 R8 R9
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/i2c_idx_engine.sv
module i2c_idx_engine
    import i2c_idx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NREGS     = 16,
    parameter logic [7:0] CNT_RESET = 8'd16,
    localparam int        IDXW      = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl,
    input  logic            sda,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [7:0]      rd_data,
    output logic [IDXW-1:0] rd_idx,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_oe
);
    localparam logic [IDXW-1:0] IDX_ONE = IDXW'(1);

    typedef struct packed {
        fsm_e            st;
        logic [7:0]      sh;
        logic [3:0]      bc;
        logic            rw;
        logic [IDXW-1:0] idx;
        logic [7:0]      cnt;
        logic [7:0]      left;
        logic            oe;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        wr_en = 1'b0;
        if (stop_det) begin
            eng_d.st = ST_IDLE;
            eng_d.oe = 1'b0;
        end else if (start_det) begin
            eng_d.st = ST_ADDR;
            eng_d.bc = 4'd0;
            eng_d.oe = 1'b0;
        end else begin
            unique case (eng_q.st)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && eng_q.bc < 4'd8) begin
                        eng_d.sh = {eng_q.sh[6:0], sda};
                        eng_d.bc = eng_q.bc + 4'd1;
                    end else if (scl_fall && eng_q.bc == 4'd8) begin
                        unique case (eng_q.st)
                            ST_ADDR: begin
                                if (eng_q.sh[7:1] == DEV_ADDR) begin
                                    eng_d.st = ST_ADDR_ACK;
                                    eng_d.rw = eng_q.sh[0];
                                    eng_d.oe = 1'b1;
                                end else begin
                                    eng_d.st = ST_IGNORE;
                                end
                            end
                            ST_INDEX: begin
                                eng_d.st = ST_INDEX_ACK;
                                eng_d.oe = 1'b1;
                            end
                            ST_COUNT: begin
                                eng_d.st = ST_COUNT_ACK;
                                eng_d.oe = 1'b1;
                            end
                            default: begin
                                if (eng_q.left != 8'd0) begin
                                    eng_d.st = ST_WDATA_ACK;
                                    eng_d.oe = 1'b1;
                                end else begin
                                    eng_d.st = ST_IGNORE;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        eng_d.bc = 4'd0;
                        if (eng_q.rw) begin
                            eng_d.st = ST_TX;
                            eng_d.sh = eng_q.cnt;
                            eng_d.oe = ~eng_q.cnt[7];
                        end else begin
                            eng_d.st = ST_INDEX;
                            eng_d.oe = 1'b0;
                        end
                    end
                end
                ST_INDEX_ACK: begin
                    if (scl_fall) begin
                        eng_d.idx = eng_q.sh[IDXW-1:0];
                        eng_d.st  = ST_COUNT;
                        eng_d.bc  = 4'd0;
                        eng_d.oe  = 1'b0;
                    end
                end
                ST_COUNT_ACK: begin
                    if (scl_fall) begin
                        eng_d.cnt  = eng_q.sh;
                        eng_d.left = eng_q.sh;
                        eng_d.st   = ST_WDATA;
                        eng_d.bc   = 4'd0;
                        eng_d.oe   = 1'b0;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        wr_en      = 1'b1;
                        eng_d.idx  = eng_q.idx + IDX_ONE;
                        eng_d.left = eng_q.left - 8'd1;
                        eng_d.st   = ST_WDATA;
                        eng_d.bc   = 4'd0;
                        eng_d.oe   = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        eng_d.bc = eng_q.bc + 4'd1;
                    end else if (scl_fall) begin
                        if (eng_q.bc == 4'd8) begin
                            eng_d.st = ST_TX_ACK;
                            eng_d.oe = 1'b0;
                        end else begin
                            eng_d.sh = {eng_q.sh[6:0], 1'b0};
                            eng_d.oe = ~eng_q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda) begin
                        eng_d.st = ST_IGNORE;
                    end else if (scl_fall) begin
                        eng_d.sh  = rd_data;
                        eng_d.idx = eng_q.idx + IDX_ONE;
                        eng_d.st  = ST_TX;
                        eng_d.bc  = 4'd0;
                        eng_d.oe  = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.cnt  <= CNT_RESET;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_idx  = eng_q.idx;
    assign wr_idx  = eng_q.idx;
    assign wr_data = eng_q.sh;
    assign sda_oe  = eng_q.oe;

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.oe) |-> !$past(scl));

    // R9
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.bc <= 4'd8);

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (eng_q.st == ST_ADDR && !eng_q.oe));

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (eng_q.st == ST_IDLE && !eng_q.oe));

    // R8
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_IGNORE) |-> !eng_q.oe);

endmodule

// File: rtl/i2c_idx_regslave.sv
module i2c_idx_regslave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREGS       = 16,
    parameter logic [7:0] CNT_RESET   = 8'd16,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDXW        = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [NREGS*8-1:0] regs_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_idx_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .NREGS     (NREGS),
        .CNT_RESET (CNT_RESET)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    i2c_reg_file #(.NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: tb/i2c_idx_regslave_test.sv
module i2c_idx_regslave_test;
    localparam int Q = 8;
    // each entry: {index, count, seed}
    localparam logic [23:0] VEC [5] = '{
        {8'd0,  8'd4,  8'h10},
        {8'd5,  8'd3,  8'hA0},
        {8'd14, 8'd4,  8'h30},
        {8'd3,  8'd1,  8'h77},
        {8'd0,  8'd16, 8'h50}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, scl_drv, sda_drv, sda_oe, sda_line;
    logic [127:0] regs;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_idx_regslave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    int n_tests = 0, n_fail = 0, viol = 0;
    logic [7:0] exp_regs [16];
    logic [7:0] wr_buf [32];
    logic [7:0] rd_buf [32];
    logic       ack_buf [40];

    always @(posedge sda_oe) if (scl_drv) viol++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; qwait();
        scl_drv = 1'b1; qwait(); qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        b = sda_line; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic host_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!host_ack);
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nsend);
        bus_start();
        put_byte(8'hD2, ack_buf[0]);
        put_byte(idx, ack_buf[1]);
        put_byte(cnt, ack_buf[2]);
        for (int k = 0; k < nsend; k++) put_byte(wr_buf[k], ack_buf[3+k]);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] idx, input int n);
        bus_start();
        put_byte(8'hD2, ack_buf[0]);
        put_byte(idx, ack_buf[1]);
        bus_start();
        put_byte(8'hD3, ack_buf[2]);
        for (int k = 0; k < n; k++) get_byte(rd_buf[k], k != n - 1);
        bus_stop();
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 16; i++)
            chk(regs[i*8 +: 8] == exp_regs[i], tag, int'(regs[i*8 +: 8]), int'(exp_regs[i]));
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic a;
        scl_drv = 1'b1; sda_drv = 1'b1; rst_n = 1'b0;
        for (int i = 0; i < 16; i++) exp_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(sda_oe == 1'b0, "R11 sda released", int'(sda_oe), 0);
        check_regs("R11 R12");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: count byte after reset is 16
        do_read(8'd0, 2);
        chk(ack_buf[0] && ack_buf[2], "R1 address ack", int'({ack_buf[0], ack_buf[2]}), 3);
        chk(rd_buf[0] == 8'd16, "R7 reset count", int'(rd_buf[0]), 16);
        chk(rd_buf[1] == 8'h00, "R5 reset reg0", int'(rd_buf[1]), 0);
        // R6: released after host NACK
        chk(sda_oe == 1'b0, "R6 release after nack", int'(sda_oe), 0);

        // table walk: write, compare bank, read back
        for (int v = 0; v < 5; v++) begin
            logic [7:0] idx, cnt, seed;
            int acks;
            {idx, cnt, seed} = VEC[v];
            for (int k = 0; k < cnt; k++) begin
                wr_buf[k] = seed + 8'(k * 7);
                exp_regs[(idx + k) % 16] = wr_buf[k];
            end
            do_write(idx, cnt, cnt);
            acks = 0;
            for (int k = 0; k < 3 + cnt; k++) acks += ack_buf[k] ? 1 : 0;
            chk(acks == 3 + cnt, "R2 write acks", acks, 3 + cnt);
            check_regs((idx + cnt > 16) ? "R3 wrap write" : "R2 R12 bank");
            do_read(idx, cnt + 1);
            chk(rd_buf[0] == cnt, "R7 count byte", int'(rd_buf[0]), int'(cnt));
            for (int k = 0; k < cnt; k++)
                chk(rd_buf[k+1] == exp_regs[(idx + k) % 16], "R5 R3 read data",
                    int'(rd_buf[k+1]), int'(exp_regs[(idx + k) % 16]));
        end

        // R4: surplus data byte NACKed and not stored
        wr_buf[0] = 8'hC1; wr_buf[1] = 8'hC2; wr_buf[2] = 8'hC3;
        exp_regs[2] = 8'hC1; exp_regs[3] = 8'hC2;
        do_write(8'd2, 8'd2, 3);
        chk(ack_buf[3] && ack_buf[4], "R4 counted bytes acked", int'({ack_buf[3], ack_buf[4]}), 3);
        chk(!ack_buf[5], "R4 surplus byte nack", int'(ack_buf[5]), 0);
        check_regs("R4 bank");

        // R8: foreign address ignored until START
        bus_start();
        put_byte(8'hA4, ack_buf[0]);
        chk(!ack_buf[0], "R8 foreign addr nack", int'(ack_buf[0]), 0);
        put_byte(8'h00, ack_buf[1]);
        put_byte(8'h01, ack_buf[2]);
        put_byte(8'hEE, ack_buf[3]);
        chk(!ack_buf[1] && !ack_buf[2] && !ack_buf[3], "R8 later bytes nack",
            int'({ack_buf[1], ack_buf[2], ack_buf[3]}), 0);
        chk(sda_oe == 1'b0, "R8 sda released", int'(sda_oe), 0);
        bus_stop();
        check_regs("R8 bank");

        // R9: START in mid-byte drops the partial byte
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'd9, a);
        put_byte(8'd2, a);
        put_byte(8'h5A, a);
        exp_regs[9] = 8'h5A;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'hD2, a);
        chk(a, "R9 address after restart", int'(a), 1);
        bus_stop();
        check_regs("R9 start abort");

        // R9: STOP in mid-byte drops the partial byte
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'd12, a);
        put_byte(8'd1, a);
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        bus_stop();
        check_regs("R9 stop abort");

        // R10: drive only began with SCL low
        chk(viol == 0, "R10 drive while scl high", viol, 0);

        summary();
        $finish;
    end
endmodule